// File: doc/BRIEF.md
# Serial interrupt slave with internal/external source routing

This block is the peripheral-side agent on a single-wire serialized interrupt bus. Every serial cycle opens with a start frame, carries one three-clock slot per IRQ number, and closes with a stop frame. For each IRQ number the block first decides which source owns the slot. The candidates are the internal devices, each with its own IRQ-select field, and the external interrupt pins, which are general-purpose pins switched to an IRQ function. The block then places the chosen level into that slot.

The line is modelled as a sampled input plus a registered drive value and output enable, for an external tristate pad with pull-up. All sampling and driving happen on the rising bus clock edge. After reset the block sits in continuous mode and waits for the host to start a cycle. The width of each stop frame then decides whether later cycles run in continuous or quiet mode. In quiet mode the block may itself open a cycle when its slot contents have changed.

Top module: `serirq_slave`

## Requirements
- R1: While rst_ni is low the output enable is 0; after reset the mode output quiet_o is 0 (continuous) and the block drives nothing until a host start frame arrives.
- R2: A start frame is a run of 4 to 8 consecutive sampled-low clocks followed by a sampled-high clock. Runs shorter than 4 or longer than 8 start no cycle and cause no drive.
- R3: If E0 is the edge that samples the first high after a valid start run, then slot s occupies the three clocks that begin at edges E0+3s (sample), E0+3s+1 (recovery) and E0+3s+2 (turnaround), for s = 0 to 15.
- R4: The slot contents are captured at E0. In a slot whose IRQ is owned by a source at low level, the block drives 0 in the sample clock, drives 1 in the recovery clock and releases in turnaround. In every other slot it stays released.
- R5: An internal device owns IRQ n when its select field equals n (n nonzero) and it counts as enabled. Its level then fills slot n, and an external pin mapped to n is ignored.
- R6: When the device selecting n is not enabled, or no device selects n, the external pins mapped to n whose function bit is 1 fill slot n. Pins whose function bit is 0 never reach the frame.
- R7: Devices 0 to 4 count as enabled only when their dev_en_i bit is 1. Devices 5 to 7 count as enabled whenever their select field is nonzero, and their dev_en_i bit has no effect. A select value of 0 claims no slot.
- R8: External pin i (0 to 10) maps, in order, to IRQ 3, 4, 5, 6, 7, 9, 10, 11, 12, 14, 15. No other IRQ number can be fed from a pin.
- R9: The stop frame is the low run after the last slot. A run of 2 clocks sets quiet_o to 1, a run of 3 clocks clears it, and any other width leaves it unchanged. The new value appears after the edge that samples the line high again.
- R10: In quiet mode, with the bus idle and high, a change of the slot contents against those captured at the last E0 makes the block drive 0 for exactly one clock, starting at the edge after the change. It does not do this in continuous mode or when contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous bus reset |
| sirq_i | input | 1 | Sampled level of the serial line |
| sirq_o | output | 1 | Value driven onto the line when enabled |
| sirq_oe_o | output | 1 | Line output enable (0 = released) |
| quiet_o | output | 1 | 1 = quiet mode, 0 = continuous mode |
| dev_irq_i | input | N_DEV | Internal device IRQ levels |
| dev_sel_i | input | N_DEV*SEL_W | IRQ-select field per device, device d at bits d*SEL_W |
| dev_en_i | input | N_DEV | Enable bit per device (used where DEV_HAS_EN is set) |
| gpio_irq_i | input | N_GPIO | External IRQ pin levels |
| gpio_irq_fn_i | input | N_GPIO | Pin function select, 1 = IRQ function |

## Verification
Slot drive for slot s is due in the clock that starts at edge E0+3s, where E0 is the first high sample after a start run. The bench drives the host side on falling edges, counts falling edges from the one that releases the line, and compares each of the 48 slot clocks at the falling edge inside it. A new mode is due one clock after the edge that sees the stop frame end, and is read at the second falling edge after the line is released. A quiet-mode request is due in the clock right after the edge following a level change. It is checked at the next falling edge, and its release is checked one falling edge later.

// File: rtl/serirq_pkg.sv
package serirq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SLOT = 2'd1,
    ST_STOP = 2'd2
  } bus_st_e;

  // bit position of the idx-th set bit of mask, -1 if none
  function automatic int nth_set_bit(logic [31:0] mask, int idx);
    int seen;
    int pos;
    seen = 0;
    pos  = -1;
    for (int b = 0; b < 32; b++) begin
      if (mask[b]) begin
        if (seen == idx && pos < 0) pos = b;
        seen++;
      end
    end
    return pos;
  endfunction

endpackage

// File: rtl/serirq_route.sv
module serirq_route
  import serirq_pkg::*;
#(
  parameter int N_IRQ  = 16,
  parameter int N_DEV  = 8,
  parameter int N_GPIO = 11,
  parameter int SEL_W  = 4,
  parameter logic [N_DEV-1:0] DEV_HAS_EN = '1,
  parameter logic [N_IRQ-1:0] ELIG_MASK  = '1
) (
  input  logic [N_DEV-1:0]       dev_irq_i,
  input  logic [N_DEV*SEL_W-1:0] dev_sel_i,
  input  logic [N_DEV-1:0]       dev_en_i,
  input  logic [N_GPIO-1:0]      gpio_irq_i,
  input  logic [N_GPIO-1:0]      gpio_irq_fn_i,
  output logic [N_IRQ-1:0]       int_claim_o,
  output logic [N_IRQ-1:0]       slot_own_o,
  output logic [N_IRQ-1:0]       slot_lvl_o
);

  logic [N_DEV-1:0] dev_live;
  logic [N_IRQ-1:0] int_lvl, ext_own, ext_lvl;

  // devices without an enable bit are live whenever a number is selected
  for (genvar d = 0; d < N_DEV; d++) begin : g_live
    if (DEV_HAS_EN[d]) begin : g_en
      assign dev_live[d] = dev_en_i[d];
    end else begin : g_noen
      assign dev_live[d] = 1'b1;
    end
  end

  always_comb begin
    int_claim_o = '0;
    int_lvl     = '0;
    for (int n = 1; n < N_IRQ; n++) begin
      for (int d = 0; d < N_DEV; d++) begin
        if (dev_live[d] && dev_sel_i[d*SEL_W +: SEL_W] == SEL_W'(n)) begin
          int_claim_o[n] = 1'b1;
          int_lvl[n]     = int_lvl[n] | dev_irq_i[d];
        end
      end
    end
  end

  always_comb begin
    ext_own = '0;
    ext_lvl = '0;
    for (int g = 0; g < N_GPIO; g++) begin
      for (int n = 0; n < N_IRQ; n++) begin
        if (gpio_irq_fn_i[g] && nth_set_bit(32'(ELIG_MASK), g) == n) begin
          ext_own[n] = 1'b1;
          ext_lvl[n] = ext_lvl[n] | gpio_irq_i[g];
        end
      end
    end
  end

  assign slot_own_o = int_claim_o | ext_own;
  assign slot_lvl_o = (int_claim_o & int_lvl) | (~int_claim_o & ext_lvl);

endmodule

// File: rtl/serirq_frame.sv
module serirq_frame
  import serirq_pkg::*;
#(
  parameter int N_IRQ     = 16,
  parameter int START_MIN = 4,
  parameter int START_MAX = 8,
  parameter int QUIET_W   = 2,
  parameter int CONT_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sirq_i,
  input  logic [N_IRQ-1:0] slot_own_i,
  input  logic [N_IRQ-1:0] slot_lvl_i,
  output logic             sirq_o,
  output logic             sirq_oe_o,
  output logic             quiet_o
);

  localparam int SW = $clog2(N_IRQ);
  localparam int CW = $clog2(START_MAX + 2);
  localparam logic [CW-1:0] CNT_SAT = CW'(START_MAX + 1);

  bus_st_e          st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [SW-1:0]    slot_q, slot_d;
  logic [1:0]       ph_q, ph_d;
  logic [N_IRQ-1:0] snap_q, snap_d, want;
  logic             req_q, req_d, mode_q, mode_d, oe_d, o_d;

  assign want = slot_own_i & ~slot_lvl_i;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    slot_d = slot_q;
    ph_d   = ph_q;
    snap_d = snap_q;
    mode_d = mode_q;
    req_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (!sirq_i) begin
          cnt_d = (cnt_q == CNT_SAT) ? cnt_q : cnt_q + 1'b1;
        end else begin
          cnt_d = '0;
          if (cnt_q >= CW'(START_MIN) && cnt_q <= CW'(START_MAX)) begin
            st_d   = ST_SLOT;
            slot_d = '0;
            ph_d   = 2'd0;
            snap_d = want;
          end else if (cnt_q == '0) begin
            req_d = mode_q && !req_q && (want != snap_q);
          end
        end
      end
      ST_SLOT: begin
        if (ph_q == 2'd2) begin
          ph_d = 2'd0;
          if (slot_q == SW'(N_IRQ - 1)) begin
            st_d  = ST_STOP;
            cnt_d = '0;
          end else begin
            slot_d = slot_q + 1'b1;
          end
        end else begin
          ph_d = ph_q + 2'd1;
        end
      end
      ST_STOP: begin
        if (!sirq_i) begin
          cnt_d = (cnt_q == CNT_SAT) ? cnt_q : cnt_q + 1'b1;
        end else if (cnt_q != '0) begin
          if (cnt_q == CW'(QUIET_W))     mode_d = 1'b1;
          else if (cnt_q == CW'(CONT_W)) mode_d = 1'b0;
          st_d  = ST_IDLE;
          cnt_d = '0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    oe_d = req_d | ((st_d == ST_SLOT) && (ph_d != 2'd2) && snap_d[slot_d]);
    o_d  = (st_d == ST_SLOT) && (ph_d == 2'd1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      slot_q    <= '0;
      ph_q      <= 2'd0;
      snap_q    <= '0;
      req_q     <= 1'b0;
      mode_q    <= 1'b0;
      sirq_oe_o <= 1'b0;
      sirq_o    <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      slot_q    <= slot_d;
      ph_q      <= ph_d;
      snap_q    <= snap_d;
      req_q     <= req_d;
      mode_q    <= mode_d;
      sirq_oe_o <= oe_d;
      sirq_o    <= o_d;
    end
  end

  assign quiet_o = mode_q;

  // R1: line released while reset is held
  always @(negedge clk_i) begin
    if (!rst_ni) a_r1_release_in_reset: assert (!sirq_oe_o);
  end

  a_r4_high_follows_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sirq_oe_o && sirq_o) |-> ($past(sirq_oe_o) && !$past(sirq_o)));

  a_r4_turnaround_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sirq_oe_o && sirq_o) |=> !sirq_oe_o);

  a_r9_mode_at_stop_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_q) |-> $past(st_q == ST_STOP));

  a_r10_request_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && sirq_oe_o) |=> !sirq_oe_o);

  a_r10_request_quiet_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && sirq_oe_o) |-> (mode_q && !sirq_o));

endmodule

// File: rtl/serirq_slave.sv
module serirq_slave #(
  parameter int N_IRQ     = 16,
  parameter int N_DEV     = 8,
  parameter int N_GPIO    = 11,
  parameter int SEL_W     = $clog2(N_IRQ),
  parameter logic [N_DEV-1:0] DEV_HAS_EN = 8'h1F,
  parameter logic [N_IRQ-1:0] ELIG_MASK  = 16'hDEF8,
  parameter int START_MIN = 4,
  parameter int START_MAX = 8,
  parameter int QUIET_W   = 2,
  parameter int CONT_W    = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sirq_i,
  output logic                   sirq_o,
  output logic                   sirq_oe_o,
  output logic                   quiet_o,
  input  logic [N_DEV-1:0]       dev_irq_i,
  input  logic [N_DEV*SEL_W-1:0] dev_sel_i,
  input  logic [N_DEV-1:0]       dev_en_i,
  input  logic [N_GPIO-1:0]      gpio_irq_i,
  input  logic [N_GPIO-1:0]      gpio_irq_fn_i
);

  logic [N_IRQ-1:0] int_claim, slot_own, slot_lvl;

  serirq_route #(
    .N_IRQ(N_IRQ), .N_DEV(N_DEV), .N_GPIO(N_GPIO), .SEL_W(SEL_W),
    .DEV_HAS_EN(DEV_HAS_EN), .ELIG_MASK(ELIG_MASK)
  ) u_route (
    .dev_irq_i    (dev_irq_i),
    .dev_sel_i    (dev_sel_i),
    .dev_en_i     (dev_en_i),
    .gpio_irq_i   (gpio_irq_i),
    .gpio_irq_fn_i(gpio_irq_fn_i),
    .int_claim_o  (int_claim),
    .slot_own_o   (slot_own),
    .slot_lvl_o   (slot_lvl)
  );

  serirq_frame #(
    .N_IRQ(N_IRQ), .START_MIN(START_MIN), .START_MAX(START_MAX),
    .QUIET_W(QUIET_W), .CONT_W(CONT_W)
  ) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sirq_i    (sirq_i),
    .slot_own_i(slot_own),
    .slot_lvl_i(slot_lvl),
    .sirq_o    (sirq_o),
    .sirq_oe_o (sirq_oe_o),
    .quiet_o   (quiet_o)
  );

  // R8: numbers outside the pin map are only ever owned by internal devices
  for (genvar n = 0; n < N_IRQ; n++) begin : g_chk
    if (!ELIG_MASK[n]) begin : g_inel
      a_r8_no_pin_on_inelig: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !int_claim[n] |-> !slot_own[n]);
    end
  end

endmodule

// File: tb/serirq_slave_tb_top.sv
`timescale 1ns/1ps
module serirq_slave_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_rel = 1'b1;
  logic dut_o, dut_oe, quiet;
  logic line;
  logic [7:0]  dev_irq = '0, dev_en = '0;
  logic [31:0] dev_sel = '0;
  logic [10:0] gpio_lvl = '1, gpio_fn = '0;

  int checks = 0, fails = 0;
  bit done = 0;
  bit exp_quiet = 0;
  int pin_irq[11] = '{3, 4, 5, 6, 7, 9, 10, 11, 12, 14, 15};

  always #10 clk = ~clk;

  assign line = dut_oe ? dut_o : host_rel;

  serirq_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sirq_i(line),
    .sirq_o(dut_o), .sirq_oe_o(dut_oe), .quiet_o(quiet),
    .dev_irq_i(dev_irq), .dev_sel_i(dev_sel), .dev_en_i(dev_en),
    .gpio_irq_i(gpio_lvl), .gpio_irq_fn_i(gpio_fn)
  );

  task automatic chk(input bit ok, input string req, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, msg, act, exp);
    end
  endtask

  // slots expected to be driven low, from R5..R8
  function automatic logic [15:0] model_drv();
    logic [15:0] r;
    r = '0;
    for (int n = 0; n < 16; n++) begin
      bit claim = 0, il = 0, eo = 0, el = 0;
      for (int d = 0; d < 8; d++)
        if (n != 0 && dev_sel[d*4 +: 4] == 4'(n) && (d >= 5 || dev_en[d])) begin
          claim = 1; il = il | dev_irq[d];
        end
      for (int g = 0; g < 11; g++)
        if (gpio_fn[g] && pin_irq[g] == n) begin
          eo = 1; el = el | gpio_lvl[g];
        end
      r[n] = (claim | eo) & ~(claim ? il : el);
    end
    return r;
  endfunction

  task automatic start_run(input int n);
    repeat (n) @(negedge clk) host_rel = 1'b0;
  endtask

  // releases the line, checks 16 slots (R3/R4), then a stop frame of width w (R9)
  task automatic frame_tail(input string req, input int w);
    logic [15:0] e;
    int bad;
    int act, expv;
    e = model_drv();
    bad = 0;
    act = 0; expv = 0;
    @(negedge clk) host_rel = 1'b1;
    for (int s = 0; s < 16; s++) begin
      for (int p = 0; p < 3; p++) begin
        bit eo, ev;
        @(negedge clk);
        eo = (p != 2) && e[s];
        ev = (p == 1);
        if (dut_oe !== eo || (eo && dut_o !== ev)) begin
          if (bad == 0) begin act = s*16 + p*4 + {dut_oe, dut_o}; expv = s*16 + p*4 + {eo, ev}; end
          bad++;
        end
      end
    end
    chk(bad == 0, req, "slot/phase/{oe,o} in R3 R4 frame", act, expv);
    repeat (w) @(negedge clk) host_rel = 1'b0;
    @(negedge clk) host_rel = 1'b1;
    if (w == 2) exp_quiet = 1;
    else if (w == 3) exp_quiet = 0;
    @(negedge clk);
    chk(quiet === exp_quiet, "R9", "mode after stop frame", quiet, exp_quiet);
  endtask

  task automatic idle_watch(input int n, input string req);
    int bad = 0;
    repeat (n) begin
      @(negedge clk);
      if (dut_oe !== 1'b0) bad++;
    end
    chk(bad == 0, req, "unexpected drive while idle", bad, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1: reset
    host_rel = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(dut_oe === 1'b0, "R1", "oe during reset", dut_oe, 0);
    end
    host_rel = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(quiet === 1'b0, "R1", "mode after reset", quiet, 0);
    gpio_fn = 11'h001; gpio_lvl = '0;
    idle_watch(20, "R1");

    // R8: each pin maps to its IRQ slot
    for (int g = 0; g < 11; g++) begin
      gpio_fn = 11'(1 << g); gpio_lvl = '0;
      start_run(6);
      frame_tail("R8", 3);
    end

    // R4: high levels and mixed pattern; R6 function bit off
    gpio_fn = '1; gpio_lvl = '1;
    start_run(6); frame_tail("R4", 3);
    gpio_lvl = 11'h555;
    start_run(5); frame_tail("R4", 3);
    gpio_fn = 11'h0F0; gpio_lvl = '0;
    start_run(6); frame_tail("R6", 3);

    // R5/R6/R7: internal vs external arbitration on IRQ 5 (pin 2)
    for (int d = 0; d < 8; d++) begin
      for (int en = 0; en < 2; en++) begin
        for (int v = 0; v < 2; v++) begin
          dev_sel = '0; dev_sel[d*4 +: 4] = 4'd5;
          dev_en  = '0; dev_en[d] = en[0];
          dev_irq = v[0] ? 8'h00 : 8'hFF;
          gpio_fn = 11'h004; gpio_lvl = v[0] ? 11'h7FF : 11'h000;
          start_run(6);
          if (d >= 5) frame_tail("R7", 3);
          else if (en == 1) frame_tail("R5", 3);
          else frame_tail("R6", 3);
        end
      end
    end
    // R7: select 0 claims nothing
    dev_sel = '0; dev_en = '0; dev_irq = '0; gpio_fn = '0; gpio_lvl = '1;
    start_run(6); frame_tail("R7", 3);
    // R5: two internal devices on distinct numbers
    dev_sel = 32'h0C00_0E00; dev_irq = '0; dev_en = '0; dev_en[2] = 1'b1;
    gpio_fn = '1; gpio_lvl = '0;
    start_run(6); frame_tail("R5", 3);

    // R2: start-run width limits
    dev_sel = '0; gpio_fn = 11'h001; gpio_lvl = '0;
    start_run(3); @(negedge clk) host_rel = 1'b1;
    idle_watch(60, "R2");
    start_run(9); @(negedge clk) host_rel = 1'b1;
    idle_watch(60, "R2");
    start_run(4); frame_tail("R2", 3);
    start_run(8); frame_tail("R2", 3);

    // R9: stop widths
    start_run(6); frame_tail("R9", 2);
    start_run(6); frame_tail("R9", 5);
    start_run(6); frame_tail("R9", 3);
    start_run(6); frame_tail("R9", 2);

    // R10: quiet-mode request
    idle_watch(10, "R10");
    @(negedge clk) gpio_lvl[0] = 1'b1;
    @(negedge clk);
    chk(dut_oe === 1'b1 && dut_o === 1'b0, "R10", "request low", {dut_oe, dut_o}, 2);
    host_rel = 1'b0;
    @(negedge clk);
    chk(dut_oe === 1'b0, "R10", "request length", dut_oe, 0);
    repeat (3) @(negedge clk) host_rel = 1'b0;
    frame_tail("R10", 3);
    @(negedge clk) gpio_lvl[0] = 1'b0;
    idle_watch(20, "R10");

    finish_run();
  end

endmodule